// File: doc/BRIEF.md
# Light sensor integration controller

This block sequences the measurements of a light-to-digital converter. The analog front end is modelled by a pulse input: the number of cycles in which `photon_pulse` is high during an integration window is the conversion result. Software programs the block through one 8-bit command write. The write selects the following:

- enable,
- one-shot or continuous operation,
- the timing source and resolution.

A free-running oscillator enable (`osc_tick`) sets the time base.

In internal timing, a window lasts a fixed power-of-two number of oscillator ticks, and the pulse count saturates at the n-bit maximum. In external timing, the window is bounded by sync strobes issued over the bus. The first strobe after the command only opens a window. Every later strobe closes the current window and, in continuous operation, opens the next one. In this mode the latched result is either the pulse count or the number of oscillator ticks in the window. The 16-bit result register feeds the data registers and changes only at the end of a conversion.

Top module: `light_integ_ctrl`

## Requirements
- R1: A command write with bit 7 (enable) at 0 stops any conversion. From the next cycle `busy` is low, `result_valid` stays low and `result` holds its value.
- R2: Bits 4:2 at 000, 001, 010 or 011 select internal timing with windows of 2^RES0_BITS, 2^RES1_BITS, 2^RES2_BITS or 2^RES3_BITS `osc_tick` cycles (16, 12, 8, 4 by default). `result_valid` pulses for one cycle in the cycle after the final tick. `result` then holds the number of sampled cycles with `photon_pulse` high inside the window.
- R3: In internal timing the pulse count saturates at 2^n-1 for the selected n and does not wrap.
- R4: Bit 6 at 0 selects one-shot operation. After one result, `busy` falls, and no further result appears until a new command write. Bit 6 at 1 selects continuous operation: windows follow each other back to back and `busy` stays high.
- R5: Bits 4:2 at 100 select external timing with the pulse count as the result. No result is produced before the first `sync_stb` after the write. Each later strobe ends the window and latches the count of pulses sampled after the opening strobe, up to and including the closing one.
- R6: Bits 4:2 at 101 select external timing with the result equal to the number of `osc_tick` cycles sampled in the same span as R5.
- R7: Bits 4:2 at 110 or 111 are reserved. They leave the block idle (`busy` low) with `result` unchanged.
- R8: A command write during a conversion discards it and starts afresh. `result` changes only in a cycle where `result_valid` is high.
- R9: After reset `result` is 0 and both `busy` and `result_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command value: [7] enable, [6] continuous, [4:2] timing/resolution, others unused |
| sync_stb | input | 1 | External-timing sync strobe from the bus |
| osc_tick | input | 1 | Oscillator cycle enable |
| photon_pulse | input | 1 | Converter pulse stream |
| result | output | 16 | Latched conversion or window-length result |
| result_valid | output | 1 | One-cycle pulse when `result` is refreshed |
| busy | output | 1 | A measurement is armed or running |

## Verification
The bench builds the block with resolution exponents of 10, 7, 5 and 3. The four internal windows are then 1024, 128, 32 and 8 ticks, so the exact window length and saturation of every resolution code can be checked in a short run. The external-timing cases use windows of a few tens of cycles and a half-rate oscillator enable, so the tick count and the pulse count of the window differ measurably.

// File: rtl/light_integ_ctrl.sv
module light_integ_ctrl #(
  parameter int RES0_BITS = 16,
  parameter int RES1_BITS = 12,
  parameter int RES2_BITS = 8,
  parameter int RES3_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_wdata,
  input  logic        sync_stb,
  input  logic        osc_tick,
  input  logic        photon_pulse,
  output logic [15:0] result,
  output logic        result_valid,
  output logic        busy
);

  localparam logic [15:0] MAX0 = 16'((32'd1 << RES0_BITS) - 32'd1);
  localparam logic [15:0] MAX1 = 16'((32'd1 << RES1_BITS) - 32'd1);
  localparam logic [15:0] MAX2 = 16'((32'd1 << RES2_BITS) - 32'd1);
  localparam logic [15:0] MAX3 = 16'((32'd1 << RES3_BITS) - 32'd1);

  typedef enum logic [1:0] {S_IDLE, S_INT, S_ARM, S_EXT} state_t;

  state_t      state;
  logic        cont_q, tmr_q, ext_q;
  logic [1:0]  win_sel;
  logic [15:0] cyc_cnt, pls_cnt;
  logic [15:0] win_max, pls_lim, pls_next, cyc_next;
  logic        int_done;

  always_comb begin
    case (win_sel)
      2'd0:    win_max = MAX0;
      2'd1:    win_max = MAX1;
      2'd2:    win_max = MAX2;
      default: win_max = MAX3;
    endcase
  end

  assign pls_lim  = (state == S_INT) ? win_max : 16'hFFFF;
  assign pls_next = (photon_pulse && pls_cnt != pls_lim) ? pls_cnt + 16'd1 : pls_cnt;
  assign cyc_next = (osc_tick && cyc_cnt != 16'hFFFF) ? cyc_cnt + 16'd1 : cyc_cnt;
  assign int_done = (state == S_INT) && osc_tick && (cyc_cnt == win_max);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cont_q       <= 1'b0;
      tmr_q        <= 1'b0;
      ext_q        <= 1'b0;
      win_sel      <= 2'd0;
      cyc_cnt      <= 16'd0;
      pls_cnt      <= 16'd0;
      result       <= 16'd0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (cmd_we) begin
        cont_q  <= cmd_wdata[6];
        ext_q   <= cmd_wdata[4];
        tmr_q   <= (cmd_wdata[4:2] == 3'b101);
        win_sel <= cmd_wdata[3:2];
        cyc_cnt <= 16'd0;
        pls_cnt <= 16'd0;
        if (!cmd_wdata[7])      state <= S_IDLE;
        else if (!cmd_wdata[4]) state <= S_INT;
        else if (!cmd_wdata[3]) state <= S_ARM;
        else                    state <= S_IDLE;
      end else begin
        case (state)
          S_INT: begin
            if (int_done) begin
              result       <= pls_next;
              result_valid <= 1'b1;
              cyc_cnt      <= 16'd0;
              pls_cnt      <= 16'd0;
              if (!cont_q) state <= S_IDLE;
            end else begin
              cyc_cnt <= cyc_next;
              pls_cnt <= pls_next;
            end
          end
          S_ARM: begin
            if (sync_stb) begin
              state   <= S_EXT;
              cyc_cnt <= 16'd0;
              pls_cnt <= 16'd0;
            end
          end
          S_EXT: begin
            if (sync_stb) begin
              result       <= tmr_q ? cyc_next : pls_next;
              result_valid <= 1'b1;
              cyc_cnt      <= 16'd0;
              pls_cnt      <= 16'd0;
              if (!cont_q) state <= S_IDLE;
            end else begin
              cyc_cnt <= cyc_next;
              pls_cnt <= pls_next;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_wdata[7]) |=> (!busy && !result_valid));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !ext_q) |-> (result <= win_max));

  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !cont_q) |-> !busy);

  assert_armed_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARM) |=> !result_valid);

  assert_reserved_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[4] && cmd_wdata[3]) |=> !busy);

  assert_result_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_valid);

endmodule

// File: tb/light_integ_ctrl_tb.sv
module light_integ_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        sync_stb = 1'b0;
  logic        osc_tick = 1'b1;
  logic        photon_pulse = 1'b0;
  logic [15:0] result;
  logic        result_valid;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int nc = 0;
  int pmode = 0;
  int tmode = 0;

  localparam int WIN [4] = '{1024, 128, 32, 8};

  always #2 clk = ~clk;

  light_integ_ctrl #(.RES0_BITS(10), .RES1_BITS(7), .RES2_BITS(5), .RES3_BITS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sync_stb(sync_stb), .osc_tick(osc_tick), .photon_pulse(photon_pulse),
    .result(result), .result_valid(result_valid), .busy(busy));

  always @(negedge clk) begin
    nc <= nc + 1;
    photon_pulse <= (pmode == 1) ? 1'b1 : (pmode == 2) ? (nc % 4 == 0) : 1'b0;
    osc_tick <= (tmode == 0) ? 1'b1 : (nc % 2 == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [7:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_stb = 1'b1;
    @(negedge clk); sync_stb = 1'b0;
  endtask

  task automatic wait_valid(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (result_valid) begin k = i; break; end
    end
  endtask

  task automatic quiet_for(input int n, input string req, input logic [15:0] hold);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (result_valid || result != hold || busy) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    check(result == 16'd0, "R9 result", int'(result), 0);
    check(!busy && !result_valid, "R9 busy/valid", int'(busy) + int'(result_valid), 0);
  endtask

  task automatic t_internal(input int sel, input int pat);
    int k;
    int exp;
    logic [15:0] r;
    pmode = pat;
    write_cmd(8'h80 | 8'(sel << 2));
    wait_valid(WIN[sel] + 10, k);
    check(k == WIN[sel], "R2 window length", k, WIN[sel]);
    exp = (pat == 1) ? WIN[sel] - 1 : WIN[sel] / 4;
    if (pat == 1) check(int'(result) == exp, "R3 saturation", int'(result), exp);
    else          check(int'(result) == exp, "R2 pulse count", int'(result), exp);
    check(!busy, "R4 one-shot busy low", int'(busy), 0);
    r = result;
    quiet_for(2 * WIN[sel] + 4, "R4 one-shot no rerun", r);
  endtask

  task automatic t_continuous();
    int k;
    logic [15:0] r;
    pmode = 2;
    write_cmd(8'hC8);
    wait_valid(50, k);
    check(k == 32, "R4 continuous first", k, 32);
    wait_valid(50, k);
    check(k == 32, "R4 continuous back-to-back", k, 32);
    check(busy && int'(result) == 8, "R4 continuous busy/result", int'(result), 8);
    write_cmd(8'h08);
    r = result;
    quiet_for(100, "R1 disable stops", r);
  endtask

  task automatic t_reserved();
    logic [15:0] r = result;
    pmode = 1;
    write_cmd(8'h98);
    quiet_for(60, "R7 reserved 110", r);
    write_cmd(8'hDC);
    quiet_for(60, "R7 reserved 111", r);
    write_cmd(8'h0C);
    quiet_for(60, "R1 enable low", r);
  endtask

  task automatic t_ext_count();
    int k;
    logic [15:0] r;
    pmode = 2;
    write_cmd(8'h90);
    wait_valid(30, k);
    check(k == 0 && busy, "R5 armed waits for sync", k, 0);
    @(negedge clk);
    pulse_sync();
    repeat (39) @(negedge clk);
    pulse_sync();
    check(result_valid && int'(result) == 10, "R5 pulse count", int'(result), 10);
    check(!busy, "R4 external one-shot", int'(busy), 0);
    r = result;
    @(negedge clk);
    pulse_sync();
    quiet_for(20, "R4 extra sync ignored", r);
  endtask

  task automatic t_ext_timer();
    pmode = 1;
    write_cmd(8'hD4);
    @(negedge clk);
    pulse_sync();
    repeat (49) @(negedge clk);
    pulse_sync();
    check(result_valid && int'(result) == 50, "R6 tick count", int'(result), 50);
    tmode = 1;
    repeat (23) @(negedge clk);
    pulse_sync();
    check(result_valid && int'(result) == 12, "R6 half-rate ticks chained", int'(result), 12);
    tmode = 0;
    write_cmd(8'h00);
  endtask

  task automatic t_restart();
    int k;
    logic [15:0] r;
    pmode = 1;
    r = result;
    write_cmd(8'h88);
    repeat (10) @(negedge clk);
    check(result == r && !result_valid, "R8 no change mid-run", int'(result), int'(r));
    write_cmd(8'h88);
    wait_valid(60, k);
    check(k == 32, "R8 restart window", k, 32);
    check(int'(result) == 31, "R8 restart result", int'(result), 31);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_internal(s, 2);
      t_internal(s, 1);
    end
    t_continuous();
    t_reserved();
    t_ext_count();
    t_ext_timer();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule